// File: doc/BRIEF.md
# Data Page Address Translator

This block turns a 16-bit logical data address into a 24-bit physical byte address. The two upper bits of the logical address pick one of four programmable page pointers. Each pointer holds a 10-bit page number that selects one of 1024 pages of 16 Kbytes. The chosen page number takes the place of those two bits, above the 14-bit in-page offset. A register write port loads the pointers. Out of reset the four pointers map the logical space linearly onto the first 64 Kbytes.

Each request carries a logical address and a word/byte flag. It may also carry an explicit page number, which bypasses the pointers. A transfer-controller flag marks accesses that go straight into segment 0 (the first 64 Kbytes) without using the pointers. The result is registered. It appears one cycle after the request, together with a valid flag, a misalignment flag for odd word addresses, and a flag that marks a target page in external memory.

Top module: `dpt_translator`

## Requirements
- R1: With neither the transfer flag nor the override set, logical bits [15:14] select pointer 0..3, and the physical address is {pointer[9:0], logical[13:0]}.
- R2: Physical bits [13:0] always equal logical bits [13:0] of the same request.
- R3: While rst_n is low, rsp_valid is 0. After reset, pointers 0, 1, 2 and 3 hold pages 0, 1, 2 and 3, so the physical address equals the logical address zero-extended.
- R4: When ptr_we is high at a clock edge, pointer ptr_sel is loaded with ptr_wdata. A request presented in the same cycle uses the old value. Requests from the next cycle on use the new value.
- R5: With req_ovr_en high and req_xfer low, the page number is req_ovr_page, and no pointer is consulted.
- R6: With req_xfer high, the physical address is {8'h00, logical[15:0]}, whatever the pointers and the override hold. The transfer flag takes precedence over the override.
- R7: rsp_misalign is 1 exactly when req_word is 1 and logical bit 0 is 1. Byte accesses never flag. The address is still produced.
- R8: A response (rsp_valid high) follows each request one clock later, and rsp_valid is low in the cycle after a cycle without a request.
- R9: rsp_external is 1 exactly when the physical page number (bits [23:14]) is 16 or more, i.e. the address is at or above 0x040000.
- R10: Logical addresses 0x3FFF and 0x4000 translate through pointers 0 and 1 respectively, so their physical results need not be adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Index of the pointer to write |
| ptr_wdata | input | 10 | Page number to write |
| req_valid | input | 1 | Translation request |
| req_addr | input | 16 | Logical byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_ovr_en | input | 1 | Use the explicit page number |
| req_ovr_page | input | 10 | Explicit page number |
| req_xfer | input | 1 | Transfer-controller access into segment 0 |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 24 | Physical byte address |
| rsp_misalign | output | 1 | Odd address on a word access |
| rsp_external | output | 1 | Target page lies in external memory |

## Verification
The bench builds the block with its default parameters: 10-bit pages, a 14-bit offset, four pointers and external memory starting at page 16. With 10-bit pages, the extreme page 0x3FF and the full 24-bit address range can be reached with a single pointer write. Because external memory starts at page 16, pages 15 and 16 sit on either side of the external boundary, and both can be reached with small override values. The bench also tests a pointer write made in the same cycle as a request, the 0x3FFF/0x4000 crossing, and a transfer access while the override is also set.

// File: rtl/dpt_pkg.sv
// Shared constants and types for the data page translator.
// Assumes: all modules of the translator import this package.
package dpt_pkg;
    localparam int DEF_PAGE_W    = 10;
    localparam int DEF_OFF_W     = 14;
    localparam int DEF_SEL_W     = 2;
    localparam int DEF_EXT_PAGE  = 16;

    // Which path produced the page number of a translation.
    typedef enum logic [1:0] {
        SRC_PTR  = 2'd0,
        SRC_OVR  = 2'd1,
        SRC_XFER = 2'd2
    } page_src_e;
endpackage

// File: rtl/dpt_ptr_bank.sv
// Bank of programmable page pointers.
// Assumes: one write per cycle; reset value of pointer i is page i.
module dpt_ptr_bank #(
    parameter int PAGE_W = 10,
    parameter int SEL_W  = 2,
    localparam int NUM   = 1 << SEL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [PAGE_W-1:0]            wdata,
    output logic [NUM-1:0][PAGE_W-1:0]   ptrs
);
    for (genvar i = 0; i < NUM; i++) begin : g_ptr
        // Hold one pointer; load on a matching write, reset to page i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptrs[i] <= PAGE_W'(i);
            else if (we && (sel == SEL_W'(i)))
                ptrs[i] <= wdata;
        end

        AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_W'(i)) |=> ptrs[i] == $past(wdata)); // R4
        AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !(we && sel == SEL_W'(i))) |=> $stable(ptrs[i])); // R4
    end
endmodule

// File: rtl/dpt_page_select.sv
// Chooses the page number for a request: transfer path, override or pointer.
// Assumes: transfer flag outranks override; purely combinational.
module dpt_page_select
    import dpt_pkg::*;
#(
    parameter int PAGE_W = 10,
    parameter int OFF_W  = 14,
    parameter int SEL_W  = 2,
    localparam int NUM   = 1 << SEL_W,
    localparam int LA_W  = SEL_W + OFF_W
) (
    input  logic [NUM-1:0][PAGE_W-1:0] ptrs,
    input  logic [LA_W-1:0]            addr,
    input  logic                       ovr_en,
    input  logic [PAGE_W-1:0]          ovr_page,
    input  logic                       xfer,
    output logic [PAGE_W-1:0]          page,
    output page_src_e                  src
);
    logic [SEL_W-1:0] idx;
    assign idx = addr[LA_W-1 -: SEL_W];

    // Priority choice of the page source.
    always_comb begin
        if (xfer) begin
            page = PAGE_W'(idx);
            src  = SRC_XFER;
        end else if (ovr_en) begin
            page = ovr_page;
            src  = SRC_OVR;
        end else begin
            page = ptrs[idx];
            src  = SRC_PTR;
        end
    end
endmodule

// File: rtl/dpt_out_stage.sv
// Output register: forms the physical address and its flags one cycle later.
// Assumes: payload is captured every cycle; only valid is reset.
module dpt_out_stage #(
    parameter int PAGE_W   = 10,
    parameter int OFF_W    = 14,
    parameter int EXT_PAGE = 16,
    localparam int PA_W    = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [OFF_W-1:0]  in_off,
    input  logic              in_word,
    output logic              out_valid,
    output logic [PA_W-1:0]   out_paddr,
    output logic              out_misalign,
    output logic              out_external
);
    logic ext_hit;
    assign ext_hit = (in_page >= PAGE_W'(EXT_PAGE));

    // Valid flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result payload: address, alignment and memory-area flags.
    always_ff @(posedge clk) begin
        out_paddr    <= {in_page, in_off};
        out_misalign <= in_word & in_off[0];
        out_external <= ext_hit;
    end
endmodule

// File: rtl/dpt_translator.sv
// Top of the data page translator: pointer bank, page select, output stage.
// Assumes: logical address is SEL_W+OFF_W bits; one request per cycle.
module dpt_translator
    import dpt_pkg::*;
#(
    parameter int PAGE_W   = DEF_PAGE_W,
    parameter int OFF_W    = DEF_OFF_W,
    parameter int SEL_W    = DEF_SEL_W,
    parameter int EXT_PAGE = DEF_EXT_PAGE,
    localparam int NUM     = 1 << SEL_W,
    localparam int LA_W    = SEL_W + OFF_W,
    localparam int PA_W    = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [PAGE_W-1:0] ptr_wdata,
    input  logic              req_valid,
    input  logic [LA_W-1:0]   req_addr,
    input  logic              req_word,
    input  logic              req_ovr_en,
    input  logic [PAGE_W-1:0] req_ovr_page,
    input  logic              req_xfer,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_misalign,
    output logic              rsp_external
);
    logic [NUM-1:0][PAGE_W-1:0] ptrs;
    logic [PAGE_W-1:0]          page;
    page_src_e                  src;

    dpt_ptr_bank #(.PAGE_W(PAGE_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(ptr_we), .sel(ptr_sel),
        .wdata(ptr_wdata), .ptrs(ptrs)
    );

    dpt_page_select #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_sel (
        .ptrs(ptrs), .addr(req_addr), .ovr_en(req_ovr_en),
        .ovr_page(req_ovr_page), .xfer(req_xfer), .page(page), .src(src)
    );

    dpt_out_stage #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .EXT_PAGE(EXT_PAGE)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_page(page),
        .in_off(req_addr[OFF_W-1:0]), .in_word(req_word),
        .out_valid(rsp_valid), .out_paddr(rsp_paddr),
        .out_misalign(rsp_misalign), .out_external(rsp_external)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid); // R3
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])); // R2
    AST_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_misalign == $past(req_word && req_addr[0])); // R7
    AST_XFER_SEG0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_xfer) |=> rsp_paddr[PA_W-1:LA_W] == '0); // R6
    AST_OVR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ovr_en && !req_xfer)
        |=> rsp_paddr[PA_W-1:OFF_W] == $past(req_ovr_page)); // R5
    AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_external ==
        (rsp_paddr[PA_W-1:OFF_W] >= PAGE_W'(EXT_PAGE))); // R9
endmodule

// File: tb/test_dpt_translator.sv
module test_dpt_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_we = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [9:0]  ptr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_ovr_en = 1'b0;
    logic [9:0]  req_ovr_page = '0;
    logic        req_xfer = 1'b0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic        rsp_misalign;
    logic        rsp_external;

    typedef struct {
        logic [23:0] paddr;
        logic        mis;
        logic        ext;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [9:0] ptr_m [4];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #5 clk = ~clk;

    dpt_translator i_dpt_translator (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_sel(ptr_sel),
        .ptr_wdata(ptr_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_ovr_en(req_ovr_en),
        .req_ovr_page(req_ovr_page), .req_xfer(req_xfer),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_misalign(rsp_misalign), .rsp_external(rsp_external)
    );

    // Driver: one cycle of stimulus; pushes the expected response.
    task automatic drive(input bit v, input logic [15:0] a, input bit w,
                         input bit oe, input logic [9:0] op, input bit x,
                         input bit we, input logic [1:0] ws,
                         input logic [9:0] wd, input string tag);
        logic [9:0] pg;
        exp_t e;
        @(negedge clk);
        req_valid = v; req_addr = a; req_word = w; req_ovr_en = oe;
        req_ovr_page = op; req_xfer = x;
        ptr_we = we; ptr_sel = ws; ptr_wdata = wd;
        if (v) begin
            if (x)       pg = {8'h00, a[15:14]};
            else if (oe) pg = op;
            else         pg = ptr_m[a[15:14]];
            e.paddr = {pg, a[13:0]};
            e.mis   = w & a[0];
            e.ext   = (pg >= 10'd16);
            e.tag   = tag;
            sb.push_back(e);
        end
        if (we) ptr_m[ws] = wd;
    endtask

    task automatic req(input logic [15:0] a, input bit w, input string tag);
        drive(1, a, w, 0, '0, 0, 0, '0, '0, tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [9:0] d);
        drive(0, '0, 0, 0, '0, 0, 1, s, d, "R4");
    endtask

    task automatic idle();
        drive(0, '0, 0, 0, '0, 0, 0, '0, '0, "R8");
    endtask

    // Monitor: compares each response with the scoreboard head.
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            if (rsp_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R8: rsp_valid=1 expected 0 (no request)");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rsp_paddr !== e.paddr || rsp_misalign !== e.mis ||
                        rsp_external !== e.ext) begin
                        fails++;
                        $display("FAIL %s: paddr=%h mis=%b ext=%b expected paddr=%h mis=%b ext=%b",
                                 e.tag, rsp_paddr, rsp_misalign, rsp_external,
                                 e.paddr, e.mis, e.ext);
                    end
                end
            end else if (sb.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R8: rsp_valid=0 expected 1");
                void'(sb.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) ptr_m[i] = 10'(i);
        // R3: a request during reset gives no response.
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R3: rsp_valid=%b expected 0 in reset", rsp_valid);
        end
        req_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R3 / R1: identity mapping out of reset.
        req(16'h0000, 0, "R3");
        req(16'h7FFE, 1, "R3");
        req(16'hC123, 0, "R1");
        req(16'h5A5A, 1, "R2");
        idle();

        // R4: pointer writes, extreme page values.
        wr(2'd0, 10'h3FF);
        wr(2'd1, 10'h005);
        req(16'h0010, 1, "R4");
        req(16'h4010, 1, "R4");
        // R4: same-cycle write and request uses the old pointer.
        drive(1, 16'h8002, 1, 0, '0, 0, 1, 2'd2, 10'h010, "R4");
        req(16'h8002, 1, "R4");
        wr(2'd3, 10'h200);
        req(16'hFFFE, 1, "R1");

        // R10: crossing 0x3FFF -> 0x4000 uses two pointers.
        req(16'h3FFF, 0, "R10");
        req(16'h4000, 0, "R10");
        idle();

        // R5: explicit page override.
        drive(1, 16'hC044, 1, 1, 10'h155, 0, 0, '0, '0, "R5");
        // R6: transfer access reaches segment 0 and outranks override.
        drive(1, 16'hFFFE, 1, 0, '0, 1, 0, '0, '0, "R6");
        drive(1, 16'h4321, 0, 1, 10'h2AA, 1, 0, '0, '0, "R6");

        // R7: alignment flag.
        req(16'h0001, 1, "R7");
        req(16'h0001, 0, "R7");
        req(16'h0002, 1, "R7");

        // R9: external boundary at page 16.
        drive(1, 16'h0100, 0, 1, 10'h00F, 0, 0, '0, '0, "R9");
        drive(1, 16'h0100, 0, 1, 10'h010, 0, 0, '0, '0, "R9");
        req(16'h8000, 0, "R9");
        idle();
        idle();
        idle();
        done = 1'b1;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d responses missing, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule